// File: doc/BRIEF.md
# SIMD Single-Lane Load-Insert Unit

This unit carries out a load of one element into one lane of a 128-bit vector register. A command supplies the present register value, an element size, a lane number, a 64-bit base address, an addressing mode and a 64-bit offset value. The unit checks the lane against the size. It issues one read on a valid/ready request channel and waits for the response beat. It then places the returned element into the chosen lane and leaves every other bit of the register as it was.

Along with the merged register, the unit returns the base address to be written back. Depending on the mode, that address is unchanged, stepped by the element's byte count, or advanced by the offset value. The read always goes to the unmodified base. Results are presented together with a one-cycle completion pulse. Only one command is in flight at a time.

Top module: `lane_load_unit`

## Requirements
- R1: Size code 0 selects a byte, 1 a halfword, 2 a word and 3 a doubleword. The legal lane range is 0 to 15, 0 to 7, 0 to 3 and 0 to 1 respectively.
- R2: When the lane is outside the range for its size, or the mode code is 3, no read is requested. The cycle after acceptance shows `done`=1 and `err`=1, with `vreg_out` equal to the accepted register value, `base_out` equal to the accepted base and `base_wr`=0.
- R3: For a legal command, `rd_req_valid` rises the cycle after acceptance. `rd_req_addr` equals the unmodified base in every mode and `rd_req_size` equals the size code. Both hold steady until `rd_req_ready` is seen high.
- R4: On completion, the bytes from lane*(1<<size) through lane*(1<<size)+(1<<size)-1 of `vreg_out` hold the low (1<<size) bytes of `rd_rsp_data` in little-endian order. All other bits equal the accepted register value.
- R5: Mode code 0 (no writeback) gives `base_out` equal to the base and `base_wr`=0.
- R6: Mode code 1 (immediate post-step) gives `base_out` equal to base + 1, 2, 4 or 8 by size, and `base_wr`=1.
- R7: Mode code 2 (register post-step) gives `base_out` equal to base + `cmd_offset` modulo 2^64, and `base_wr`=1.
- R8: `done` is high for exactly one cycle, the cycle after the response beat is taken. `vreg_out`, `base_out` and `base_wr` then hold until the next completion.
- R9: `cmd_ready` is high only when idle. A `cmd_valid` presented while busy is ignored and has no effect on the request or the result.
- R10: After reset, `cmd_ready`=1 and `done`, `err` and `rd_req_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit idle, command taken this cycle if valid |
| cmd_size | input | 2 | Element size code |
| cmd_lane | input | 4 | Lane number |
| cmd_mode | input | 2 | Writeback mode code |
| cmd_base | input | 64 | Base address |
| cmd_offset | input | 64 | Register offset for mode 2 |
| vreg_in | input | 128 | Current vector register value |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | 64 | Read byte address |
| rd_req_size | output | 2 | Read size code |
| rd_rsp_valid | input | 1 | Read data beat valid |
| rd_rsp_data | input | 64 | Read data, element in low bits |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Completion was an illegal command |
| vreg_out | output | 128 | Merged vector register |
| base_out | output | 64 | Base address for writeback |
| base_wr | output | 1 | Writeback of base required |

## Verification
An accepted legal command raises its read request one cycle later. The completion outputs appear one cycle after the response beat is taken. An illegal command completes with its error one cycle after acceptance. The bench drives and samples on falling edges, so each check lands exactly in the cycle the requirement names. It also confirms that `done` has dropped and the results are unchanged one cycle later. Request stalls of several cycles and busy-time command injection push the response edge later, and every check is counted from that handshake rather than from the command.

// File: rtl/lane_load_pkg.sv
// Package: shared codes for the single-lane load-insert unit.
// Assumes the size code is log2 of the element byte count.
package lane_load_pkg;
    typedef enum logic [1:0] {
        ESZ_B = 2'd0,
        ESZ_H = 2'd1,
        ESZ_W = 2'd2,
        ESZ_D = 2'd3
    } elem_size_e;

    typedef enum logic [1:0] {
        WB_NONE = 2'd0,
        WB_IMM  = 2'd1,
        WB_REG  = 2'd2,
        WB_RSVD = 2'd3
    } wb_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_DONE = 2'd3
    } ctl_state_e;
endpackage

// File: rtl/lane_index_check.sv
// Module: lane_index_check
// Decides whether a lane number fits inside the vector for a given size.
// Assumes VBYTES is a power of two and the size code is log2(element bytes).
module lane_index_check #(
    parameter int VBYTES = 16
) (
    input  logic [1:0]                 size,
    input  logic [$clog2(VBYTES)-1:0]  lane,
    output logic                       legal
);
    localparam int LANE_W = $clog2(VBYTES);
    localparam logic [LANE_W:0] VB = (LANE_W+1)'(VBYTES);

    // Purpose: lane count for this size is VBYTES >> size.
    always_comb begin
        legal = {1'b0, lane} < (VB >> size);
    end
endmodule

// File: rtl/lane_merge.sv
// Module: lane_merge
// Replaces the bytes of one lane with the low bytes of the read data.
// Assumes the lane is legal for the size and DBYTES covers the largest element.
module lane_merge #(
    parameter int VBYTES = 16,
    parameter int DBYTES = 8
) (
    input  logic [1:0]                 size,
    input  logic [$clog2(VBYTES)-1:0]  lane,
    input  logic [VBYTES*8-1:0]        vreg_in,
    input  logic [DBYTES*8-1:0]        rdata,
    output logic [VBYTES*8-1:0]        vreg_out
);
    localparam int LANE_W = $clog2(VBYTES);
    localparam int POS_W  = LANE_W + 3;
    localparam int DSEL_W = $clog2(DBYTES);

    logic [POS_W-1:0] elem_off;
    logic [POS_W-1:0] elem_len;

    // Purpose: first byte and byte count of the addressed lane.
    always_comb begin
        elem_off = POS_W'(lane) << size;
        elem_len = POS_W'(1) << size;
    end

    for (genvar b = 0; b < VBYTES; b++) begin : g_byte
        localparam logic [POS_W-1:0] BPOS = POS_W'(b);
        logic [POS_W-1:0] rel;
        logic             hit;
        logic [7:0]       byte_q;

        // Purpose: choose read byte or kept byte for this position.
        always_comb begin
            rel    = BPOS - elem_off;
            hit    = (BPOS >= elem_off) && (rel < elem_len);
            byte_q = hit ? rdata[rel[DSEL_W-1:0]*8 +: 8] : vreg_in[b*8 +: 8];
        end
        assign vreg_out[b*8 +: 8] = byte_q;
    end
endmodule

// File: rtl/base_writeback.sv
// Module: base_writeback
// Produces the written-back base address and its enable from the mode.
// Assumes mode code 3 never reaches here as a valid completion.
module base_writeback #(
    parameter int ADDR_W = 64
) (
    input  logic [1:0]        mode,
    input  logic [1:0]        size,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] offset,
    output logic [ADDR_W-1:0] next_base,
    output logic              wr_en
);
    import lane_load_pkg::*;

    logic [ADDR_W-1:0] step;

    // Purpose: select the step and add it to the base.
    always_comb begin
        step = ADDR_W'(1) << size;
        unique case (wb_mode_e'(mode))
            WB_IMM: begin
                next_base = base + step;
                wr_en     = 1'b1;
            end
            WB_REG: begin
                next_base = base + offset;
                wr_en     = 1'b1;
            end
            default: begin
                next_base = base;
                wr_en     = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/lane_load_unit.sv
// Module: lane_load_unit (top)
// Accepts one load-to-lane command, reads the element through a valid/ready
// request and a response beat, merges it into the register, and reports the
// merged register and the writeback base with a one-cycle done pulse.
// Assumes the memory side returns exactly one response beat per request,
// only after the request has been accepted.
module lane_load_unit #(
    parameter int VREG_W = 128,
    parameter int ADDR_W = 64,
    parameter int DATA_W = 64
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cmd_valid,
    output logic                        cmd_ready,
    input  logic [1:0]                  cmd_size,
    input  logic [$clog2(VREG_W/8)-1:0] cmd_lane,
    input  logic [1:0]                  cmd_mode,
    input  logic [ADDR_W-1:0]           cmd_base,
    input  logic [ADDR_W-1:0]           cmd_offset,
    input  logic [VREG_W-1:0]           vreg_in,
    output logic                        rd_req_valid,
    input  logic                        rd_req_ready,
    output logic [ADDR_W-1:0]           rd_req_addr,
    output logic [1:0]                  rd_req_size,
    input  logic                        rd_rsp_valid,
    input  logic [DATA_W-1:0]           rd_rsp_data,
    output logic                        done,
    output logic                        err,
    output logic [VREG_W-1:0]           vreg_out,
    output logic [ADDR_W-1:0]           base_out,
    output logic                        base_wr
);
    import lane_load_pkg::*;

    localparam int VBYTES = VREG_W / 8;
    localparam int DBYTES = DATA_W / 8;
    localparam int LANE_W = $clog2(VBYTES);

    ctl_state_e        state;
    logic [1:0]        lat_size;
    logic [LANE_W-1:0] lat_lane;
    logic [1:0]        lat_mode;
    logic [ADDR_W-1:0] lat_base;
    logic [ADDR_W-1:0] lat_off;
    logic [VREG_W-1:0] lat_vreg;
    logic [VREG_W-1:0] res_vreg;
    logic [ADDR_W-1:0] res_base;
    logic              res_wr;
    logic              res_err;

    logic              lane_ok;
    logic              cmd_bad;
    logic [VREG_W-1:0] merged;
    logic [ADDR_W-1:0] wb_base;
    logic              wb_en;

    lane_index_check #(.VBYTES(VBYTES)) idx_chk_i (
        .size  (cmd_size),
        .lane  (cmd_lane),
        .legal (lane_ok)
    );

    lane_merge #(.VBYTES(VBYTES), .DBYTES(DBYTES)) merge_i (
        .size     (lat_size),
        .lane     (lat_lane),
        .vreg_in  (lat_vreg),
        .rdata    (rd_rsp_data),
        .vreg_out (merged)
    );

    base_writeback #(.ADDR_W(ADDR_W)) wb_i (
        .mode      (lat_mode),
        .size      (lat_size),
        .base      (lat_base),
        .offset    (lat_off),
        .next_base (wb_base),
        .wr_en     (wb_en)
    );

    // Purpose: a command is rejected for a bad lane or the reserved mode.
    always_comb begin
        cmd_bad = !lane_ok || (wb_mode_e'(cmd_mode) == WB_RSVD);
    end

    // Purpose: control sequence and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            lat_size <= '0;
            lat_lane <= '0;
            lat_mode <= '0;
            lat_base <= '0;
            lat_off  <= '0;
            lat_vreg <= '0;
            res_vreg <= '0;
            res_base <= '0;
            res_wr   <= 1'b0;
            res_err  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        lat_size <= cmd_size;
                        lat_lane <= cmd_lane;
                        lat_mode <= cmd_mode;
                        lat_base <= cmd_base;
                        lat_off  <= cmd_offset;
                        lat_vreg <= vreg_in;
                        if (cmd_bad) begin
                            res_vreg <= vreg_in;
                            res_base <= cmd_base;
                            res_wr   <= 1'b0;
                            res_err  <= 1'b1;
                            state    <= ST_DONE;
                        end else begin
                            res_err  <= 1'b0;
                            state    <= ST_REQ;
                        end
                    end
                end
                ST_REQ: begin
                    if (rd_req_ready) begin
                        state <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (rd_rsp_valid) begin
                        res_vreg <= merged;
                        res_base <= wb_base;
                        res_wr   <= wb_en;
                        state    <= ST_DONE;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // Purpose: drive the port view of the state and results.
    always_comb begin
        cmd_ready    = (state == ST_IDLE);
        rd_req_valid = (state == ST_REQ);
        rd_req_addr  = lat_base;
        rd_req_size  = lat_size;
        done         = (state == ST_DONE);
        err          = done && res_err;
        vreg_out     = res_vreg;
        base_out     = res_base;
        base_wr      = res_wr;
    end
endmodule

// File: rtl/lane_load_unit_chk.sv
// Module: lane_load_unit_chk
// Protocol and result checks for lane_load_unit, bound to every instance.
// Keeps its own copy of the accepted command to judge the completion.
module lane_load_unit_chk #(
    parameter int VREG_W = 128,
    parameter int ADDR_W = 64
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        cmd_valid,
    input logic                        cmd_ready,
    input logic [1:0]                  cmd_size,
    input logic [$clog2(VREG_W/8)-1:0] cmd_lane,
    input logic [1:0]                  cmd_mode,
    input logic [ADDR_W-1:0]           cmd_base,
    input logic [ADDR_W-1:0]           cmd_offset,
    input logic                        rd_req_valid,
    input logic                        rd_req_ready,
    input logic [ADDR_W-1:0]           rd_req_addr,
    input logic                        done,
    input logic                        err,
    input logic [ADDR_W-1:0]           base_out,
    input logic                        base_wr
);
    localparam int LANE_W = $clog2(VREG_W/8);
    localparam logic [LANE_W:0] NB = (LANE_W+1)'(VREG_W/8);

    logic              accept;
    logic              bad_cmd;
    logic [ADDR_W-1:0] c_base;
    logic [ADDR_W-1:0] c_off;
    logic [1:0]        c_mode;
    logic [1:0]        c_size;

    // Purpose: observe acceptance and legality at the ports.
    always_comb begin
        accept  = cmd_valid && cmd_ready;
        bad_cmd = (cmd_mode == 2'd3) || ({1'b0, cmd_lane} >= (NB >> cmd_size));
    end

    // Purpose: remember the accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_base <= '0;
            c_off  <= '0;
            c_mode <= '0;
            c_size <= '0;
        end else if (accept) begin
            c_base <= cmd_base;
            c_off  <= cmd_offset;
            c_mode <= cmd_mode;
            c_size <= cmd_size;
        end
    end

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_busy_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done || rd_req_valid) |-> !cmd_ready);

    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));

    p_req_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |-> (rd_req_addr == c_base));

    p_legal_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !bad_cmd) |=> (rd_req_valid && !done));

    p_illegal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && bad_cmd) |=> (done && err && !rd_req_valid && !base_wr));

    p_err_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    p_nowb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err && c_mode == 2'd0) |-> (!base_wr && base_out == c_base));

    p_immwb_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err && c_mode == 2'd1) |->
            (base_wr && base_out == c_base + (ADDR_W'(1) << c_size)));

    p_regwb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err && c_mode == 2'd2) |-> (base_wr && base_out == c_base + c_off));
endmodule

bind lane_load_unit lane_load_unit_chk #(.VREG_W(VREG_W), .ADDR_W(ADDR_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_ready    (cmd_ready),
    .cmd_size     (cmd_size),
    .cmd_lane     (cmd_lane),
    .cmd_mode     (cmd_mode),
    .cmd_base     (cmd_base),
    .cmd_offset   (cmd_offset),
    .rd_req_valid (rd_req_valid),
    .rd_req_ready (rd_req_ready),
    .rd_req_addr  (rd_req_addr),
    .done         (done),
    .err          (err),
    .base_out     (base_out),
    .base_wr      (base_wr)
);

// File: tb/lane_load_unit_tb_top.sv
// Directed bench for lane_load_unit; acts as the memory side itself.
module lane_load_unit_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0;
    logic         cmd_ready;
    logic [1:0]   cmd_size = '0;
    logic [3:0]   cmd_lane = '0;
    logic [1:0]   cmd_mode = '0;
    logic [63:0]  cmd_base = '0;
    logic [63:0]  cmd_offset = '0;
    logic [127:0] vreg_in = '0;
    logic         rd_req_valid;
    logic         rd_req_ready = 1'b0;
    logic [63:0]  rd_req_addr;
    logic [1:0]   rd_req_size;
    logic         rd_rsp_valid = 1'b0;
    logic [63:0]  rd_rsp_data = '0;
    logic         done;
    logic         err;
    logic [127:0] vreg_out;
    logic [63:0]  base_out;
    logic         base_wr;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    lane_load_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_size(cmd_size), .cmd_lane(cmd_lane), .cmd_mode(cmd_mode),
        .cmd_base(cmd_base), .cmd_offset(cmd_offset), .vreg_in(vreg_in),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
        .rd_req_addr(rd_req_addr), .rd_req_size(rd_req_size),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
        .done(done), .err(err), .vreg_out(vreg_out), .base_out(base_out),
        .base_wr(base_wr)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One command end to end; stall = request cycles held off, inject = busy cmd.
    task automatic run_cmd(input logic [1:0] size, input logic [3:0] lane,
                           input logic [1:0] mode, input logic [63:0] base,
                           input logic [63:0] off, input logic [127:0] vin,
                           input logic [63:0] data, input int stall,
                           input bit inject, input bit expect_bad, input string tag);
        int nb;
        logic [127:0] exp_v;
        logic [63:0]  exp_b;
        nb    = 1 << size;
        exp_v = vin;
        for (int i = 0; i < nb; i++) exp_v[(lane*nb + i)*8 +: 8] = data[i*8 +: 8];
        exp_b = (mode == 2'd1) ? base + 64'(nb) : (mode == 2'd2) ? base + off : base;

        @(negedge clk);
        check(cmd_ready == 1'b1, "R9", {tag, " ready when idle"}, 128'(cmd_ready), 128'(1));
        cmd_valid = 1'b1; cmd_size = size; cmd_lane = lane; cmd_mode = mode;
        cmd_base = base; cmd_offset = off; vreg_in = vin;
        @(negedge clk);
        cmd_valid = 1'b0;
        vreg_in   = ~vin;
        if (expect_bad) begin
            check(done && err && !rd_req_valid, "R2", {tag, " error completion"},
                  128'({done, err, rd_req_valid}), 128'(3'b110));
            check(vreg_out == vin, "R2", {tag, " register unchanged"}, vreg_out, vin);
            check(base_out == base && !base_wr, "R2", {tag, " base kept"},
                  128'({base_wr, base_out}), 128'({1'b0, base}));
            @(negedge clk);
            check(!done && cmd_ready, "R8", {tag, " error pulse ends"},
                  128'({done, cmd_ready}), 128'(2'b01));
            return;
        end
        check(rd_req_valid && !cmd_ready, "R3", {tag, " request raised"},
              128'({rd_req_valid, cmd_ready}), 128'(2'b10));
        check(rd_req_addr == base && rd_req_size == size, "R3", {tag, " request fields"},
              128'({rd_req_size, rd_req_addr}), 128'({size, base}));
        for (int s = 0; s < stall; s++) begin
            if (inject) begin
                cmd_valid = 1'b1; cmd_base = base ^ 64'hFF00; cmd_mode = 2'd2;
                cmd_lane = 4'd0; cmd_size = 2'd3; cmd_offset = 64'h1234;
            end
            @(negedge clk);
            check(rd_req_valid && rd_req_addr == base, "R9", {tag, " request held while busy"},
                  128'({rd_req_valid, rd_req_addr}), 128'({1'b1, base}));
        end
        cmd_valid    = 1'b0;
        rd_req_ready = 1'b1;
        @(negedge clk);
        rd_req_ready = 1'b0;
        check(!rd_req_valid && !done, "R3", {tag, " request dropped after ready"},
              128'({rd_req_valid, done}), 128'(0));
        rd_rsp_valid = 1'b1;
        rd_rsp_data  = data;
        @(negedge clk);
        rd_rsp_valid = 1'b0;
        rd_rsp_data  = ~data;
        check(done && !err, "R8", {tag, " done pulse"}, 128'({done, err}), 128'(2'b10));
        check(vreg_out == exp_v, "R4", {tag, " merged register"}, vreg_out, exp_v);
        check(base_out == exp_b, (mode == 2'd0) ? "R5" : (mode == 2'd1) ? "R6" : "R7",
              {tag, " base writeback"}, 128'(base_out), 128'(exp_b));
        check(base_wr == (mode != 2'd0), "R5", {tag, " writeback enable"},
              128'(base_wr), 128'(mode != 2'd0));
        @(negedge clk);
        check(!done && cmd_ready && vreg_out == exp_v && base_out == exp_b, "R8",
              {tag, " pulse ends, results hold"}, vreg_out, exp_v);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(cmd_ready && !done && !err && !rd_req_valid, "R10", "reset state",
              128'({cmd_ready, done, err, rd_req_valid}), 128'(4'b1000));
    endtask

    task automatic t_byte_lanes();
        // R1 byte: lanes 0 and 15 legal
        run_cmd(2'd0, 4'd0,  2'd0, 64'h1000, 64'h0, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210,
                64'hDEAD_BEEF_CAFE_F00D, 0, 0, 0, "R1 byte lane0 nowb");
        run_cmd(2'd0, 4'd15, 2'd1, 64'h2000, 64'h0, {16{8'h5A}},
                64'h1122_3344_5566_77A5, 1, 0, 0, "R6 byte lane15 imm");
    endtask

    task automatic t_half_word();
        run_cmd(2'd1, 4'd7, 2'd2, 64'h3000, 64'h40, {8{16'hA5A5}},
                64'hFFFF_FFFF_FFFF_1234, 0, 0, 0, "R7 half lane7 reg");
        run_cmd(2'd2, 4'd2, 2'd1, 64'h4004, 64'h0, {4{32'h0F0F_0F0F}},
                64'h9999_9999_8765_4321, 3, 1, 0, "R9 word lane2 imm busy");
    endtask

    task automatic t_dword();
        run_cmd(2'd3, 4'd1, 2'd2, 64'hFFFF_FFFF_FFFF_FFF0, 64'h20, {2{64'h0}},
                64'h0102_0304_0506_0708, 0, 0, 0, "R7 dword lane1 wrap");
        run_cmd(2'd3, 4'd0, 2'd1, 64'h8000, 64'h0, {2{64'hFFFF_FFFF_FFFF_FFFF}},
                64'hA1B2_C3D4_E5F6_0718, 2, 0, 0, "R6 dword lane0 imm");
    endtask

    task automatic t_illegal();
        run_cmd(2'd2, 4'd4, 2'd1, 64'h5000, 64'h0, {4{32'h1357_9BDF}},
                64'h0, 0, 0, 1, "R2 word lane4");
        run_cmd(2'd3, 4'd2, 2'd0, 64'h6000, 64'h0, {2{64'h2468_ACE0_1357_9BDF}},
                64'h0, 0, 0, 1, "R2 dword lane2");
        run_cmd(2'd1, 4'd8, 2'd2, 64'h6100, 64'h8, {8{16'h7E7E}},
                64'h0, 0, 0, 1, "R1 half lane8");
        run_cmd(2'd0, 4'd3, 2'd3, 64'h7000, 64'h0, {16{8'h3C}},
                64'h0, 0, 0, 1, "R2 reserved mode");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_byte_lanes();
        t_half_word();
        t_dword();
        t_illegal();
        run_cmd(2'd2, 4'd3, 2'd0, 64'h9000, 64'h0, {4{32'hCCCC_CCCC}},
                64'hFFFF_FFFF_0000_0001, 0, 0, 0, "R5 word lane3 nowb");
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule